// File: doc/BRIEF.md
# Cascadable Serial Command and Data Shift Register

This block is the device-side end of a serial link on a data converter. A single 32-bit register does three jobs at once. It holds the result word that is sent to the host, it gathers the command word that the host sends, and it passes bits on to the next device when several identical devices are wired in a cascade. An active-low frame strobe, a serial clock and a serial input arrive asynchronously. They are synchronised into the system clock, and all edge detection happens in that domain.

When the strobe falls, the register takes the parallel result word and its top bit appears on the serial output. Each rising serial-clock edge (the capture edge) shifts the serial input into the bottom of the register. Each falling edge (the launch edge) puts the new top bit on the output. When the strobe rises, whatever the register holds at that moment is published as the command word, together with a one-cycle valid pulse. The frame may have any length.

In a cascade, the output of each device feeds the input of the next, and all devices share the strobe and the serial clock. The host therefore reads the last device's word first. A frame that is 32 bits per device leaves each device holding its own command.

Top module: `daisy_shift_port`

## Requirements
- R1: While reset is held and just after it is released, `sdo_out`, `cmd_valid` and `cmd_word` are all zero.
- R2: A falling edge of `frm_sel` loads `load_word` into the register and drives its bit 31 onto `sdo_out` before the first capture edge. Changes to `load_word` later in that frame have no effect on the bits sent.
- R3: Each falling `sclk_in` edge inside a frame drives the register's new bit 31 onto `sdo_out`, so the host receives the loaded word MSB first.
- R4: Each rising `sclk_in` edge inside a frame shifts the register left by one and puts `sdi_in` into bit 0. After more than 32 edges, `sdo_out` repeats the input delayed by 32 bits.
- R5: At each rising edge of `frm_sel`, `cmd_word` takes the register contents, whatever number of bits was shifted (fewer than, exactly, or more than 32). `cmd_word` changes at no other time.
- R6: `cmd_valid` is high for exactly one system clock after each rising edge of `frm_sel`.
- R7: `sdo_out` is low whenever no frame is in progress, including right after the strobe rises.
- R8: With two devices chained (the first device's output feeding the second's input) and a 64-bit frame, the host receives the second device's word, then the first device's. The first device decodes the last 32 bits sent and the second device decodes the first 32.
- R9: A capture edge that reaches the system clock domain in the same cycle as the strobe's rising edge is shifted in before the command is taken.
- R10: Serial clock edges while `frm_sel` is high leave the register and `sdo_out` unchanged. A frame with no clock edges decodes the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_sel | input | 1 | Frame strobe, asynchronous. Low = frame in progress; the rising edge is the sample and decode instant |
| sclk_in | input | 1 | Serial clock, asynchronous. Rising = capture, falling = launch |
| sdi_in | input | 1 | Serial data in, from the host or the previous device |
| load_word | input | 32 | Parallel result word taken at frame start |
| sdo_out | output | 1 | Serial data out, to the host or the next device |
| cmd_word | output | 32 | Register contents taken at the strobe's rising edge |
| cmd_valid | output | 1 | One-cycle pulse marking a new `cmd_word` |

## Verification
Two events can land in the same system clock cycle: the final capture edge and the strobe's rising edge. Both pass through synchronisers of equal depth, so the bench provokes the collision by changing `sclk_in` and `frm_sel` in the same input step. The case is judged correct when the decoded word contains the bit that was shifted in that cycle (R9), which is the same word a normally spaced 32-bit frame produces.

// File: rtl/dsr_pkg.sv
// Package: shared indices and event bundle for the cascadable shift port.
// Assumes the three asynchronous inputs are carried as one vector in the
// bit order given by the indices below.
package dsr_pkg;
    localparam int unsigned IDX_STB = 0;
    localparam int unsigned IDX_SCK = 1;
    localparam int unsigned IDX_SDI = 2;
    localparam int unsigned N_IN    = 3;

    // One-cycle event pulses in the system clock domain
    typedef struct packed {
        logic frame_start;
        logic frame_end;
        logic capture;
        logic launch;
    } ser_evt_t;
endpackage

// File: rtl/sync_bus.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; STAGES must be at least 2.
module sync_bus #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Move the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/edge_det.sv
// Module: rise and fall detector for synchronised levels.
// Assumes the inputs are already in the clk domain; pulses last one cycle.
module edge_det #(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    // Keep last cycle's level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/frame_shifter.sv
// Module: the shared data/command shift register and its serial output.
// Assumes event pulses come from edge_det; capture and launch never coincide.
// Frame start takes priority over any serial edge in the same cycle.
module frame_shifter
    import dsr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ser_evt_t     evt,
    input  logic         sdi,
    input  logic [W-1:0] load_word,
    output logic         sdo,
    output logic         frame_active,
    output logic [W-1:0] word_d
);
    logic [W-1:0] word_q;
    logic         sdo_q;
    logic         act_q;

    // Next register value: load at start, shift on capture inside a frame
    always_comb begin
        word_d = word_q;
        if (evt.frame_start)              word_d = load_word;
        else if (act_q && evt.capture)    word_d = {word_q[W-2:0], sdi};
    end

    // Register, frame flag and output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            sdo_q  <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            word_q <= word_d;
            if (evt.frame_start) begin
                sdo_q <= load_word[W-1];
                act_q <= 1'b1;
            end else if (evt.frame_end) begin
                sdo_q <= 1'b0;
                act_q <= 1'b0;
            end else if (act_q && evt.launch) begin
                sdo_q <= word_q[W-1];
            end
        end
    end

    assign sdo          = sdo_q & act_q;
    assign frame_active = act_q;
endmodule

// File: rtl/cmd_latch.sv
// Module: publishes the register contents as a command at frame end.
// Assumes `take` is a one-cycle pulse; word_d already holds any final shift.
module cmd_latch #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] word_d,
    output logic [W-1:0] cmd_word,
    output logic         cmd_valid
);
    // Capture the command word and raise the single-cycle valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= take;
            if (take) cmd_word <= word_d;
        end
    end
endmodule

// File: rtl/daisy_shift_port.sv
// Module: top of the cascadable serial shift port.
// Assumes strobe, serial clock and serial input are asynchronous to clk and
// that each serial half period is several system clocks long. The strobe
// idles high.
module daisy_shift_port
    import dsr_pkg::*;
#(
    parameter int unsigned REG_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_sel,
    input  logic             sclk_in,
    input  logic             sdi_in,
    input  logic [REG_W-1:0] load_word,
    output logic             sdo_out,
    output logic [REG_W-1:0] cmd_word,
    output logic             cmd_valid
);
    localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << IDX_STB;
    localparam logic [1:0]      EDGE_RST = SYNC_RST[1:0];

    logic [N_IN-1:0]  raw_v;
    logic [N_IN-1:0]  syn_v;
    logic [1:0]       rise_v;
    logic [1:0]       fall_v;
    ser_evt_t         evt;
    logic             frame_active;
    logic [REG_W-1:0] word_d;

    // Gather the asynchronous inputs in package index order
    always_comb begin
        raw_v          = '0;
        raw_v[IDX_STB] = frm_sel;
        raw_v[IDX_SCK] = sclk_in;
        raw_v[IDX_SDI] = sdi_in;
    end

    sync_bus #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_v), .dout(syn_v)
    );

    edge_det #(.WIDTH(2), .RST_VAL(EDGE_RST)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn_v[1:0]), .rise(rise_v), .fall(fall_v)
    );

    // Map detected edges onto frame and serial events
    always_comb begin
        evt.frame_start = fall_v[IDX_STB];
        evt.frame_end   = rise_v[IDX_STB];
        evt.capture     = rise_v[IDX_SCK];
        evt.launch      = fall_v[IDX_SCK];
    end

    frame_shifter #(.W(REG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .evt(evt), .sdi(syn_v[IDX_SDI]),
        .load_word(load_word), .sdo(sdo_out), .frame_active(frame_active),
        .word_d(word_d)
    );

    cmd_latch #(.W(REG_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .take(evt.frame_end), .word_d(word_d),
        .cmd_word(cmd_word), .cmd_valid(cmd_valid)
    );
endmodule

// File: rtl/daisy_shift_port_chk.sv
// Module: property checker bound to daisy_shift_port.
// Assumes it is attached through the bind below and sees the top's signals.
module daisy_shift_port_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_start,
    input logic         frame_end,
    input logic         frame_active,
    input logic         load_msb,
    input logic         sdo_out,
    input logic [W-1:0] cmd_word,
    input logic         cmd_valid
);
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(frame_end));

    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_word) |-> cmd_valid);

    p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_start) |-> (sdo_out == $past(load_msb)));

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end) |-> !sdo_out);

    p_frame_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_active);
endmodule

bind daisy_shift_port daisy_shift_port_chk #(.W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .frame_start(evt.frame_start), .frame_end(evt.frame_end),
    .frame_active(frame_active), .load_msb(load_word[REG_W-1]),
    .sdo_out(sdo_out), .cmd_word(cmd_word), .cmd_valid(cmd_valid)
);

// File: tb/daisy_shift_port_tb.sv
module daisy_shift_port_tb;
    localparam int W    = 32;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_sel = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdi_in = 1'b0;
    logic [W-1:0] load_word = '0;
    logic         sdo_a, sdo_b;
    logic [W-1:0] cmd_a, cmd_b;
    logic         val_a, val_b;
    bit           use_chain = 1'b0;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int bad_pulses = 0;
    int run_len = 0;
    int frames = 0;

    always #2 clk = ~clk;

    daisy_shift_port u_dut (
        .clk(clk), .rst_n(rst_n), .frm_sel(frm_sel), .sclk_in(sclk_in),
        .sdi_in(sdi_in), .load_word(load_word), .sdo_out(sdo_a),
        .cmd_word(cmd_a), .cmd_valid(val_a)
    );

    daisy_shift_port u_next (
        .clk(clk), .rst_n(rst_n), .frm_sel(frm_sel), .sclk_in(sclk_in),
        .sdi_in(sdo_a), .load_word(load_word), .sdo_out(sdo_b),
        .cmd_word(cmd_b), .cmd_valid(val_b)
    );

    // Measure the width of every valid pulse on the first device
    always @(negedge clk) begin
        if (val_a) run_len++;
        else if (run_len > 0) begin
            pulses++;
            if (run_len != 1) bad_pulses++;
            run_len = 0;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of n bits; tx[n-1] is sent first
    task automatic run_frame(input int n, input logic [127:0] tx, input logic [W-1:0] ld,
                             input bit coincide, output logic [127:0] rx);
        rx = '0;
        @(negedge clk);
        load_word = ld;
        wait_n(2);
        frm_sel = 1'b0;
        wait_n(HALF);
        load_word = ~ld;
        for (int i = 0; i < n; i++) begin
            sdi_in = tx[n-1-i];
            wait_n(HALF);
            rx = {rx[126:0], (use_chain ? sdo_b : sdo_a)};
            if (coincide && i == n - 1) begin
                sclk_in = 1'b1;
                frm_sel = 1'b1;
                wait_n(HALF);
                sclk_in = 1'b0;
            end else begin
                sclk_in = 1'b1;
                wait_n(HALF);
                sclk_in = 1'b0;
            end
        end
        if (!(coincide && n > 0)) begin
            wait_n(HALF);
            frm_sel = 1'b1;
        end
        frames++;
        wait_n(12);
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R1 sdo in reset", sdo_a, 0);
        rst_n = 1'b1;
        wait_n(4);
        check("R1 sdo", sdo_a, 0);
        check("R1 valid", val_a, 0);
        check("R1 cmd", cmd_a, 0);
    endtask

    task automatic t_single();
        logic [127:0] rx;
        run_frame(32, 128'h1234_5678, 32'hA5C3_1E97, 1'b0, rx);
        check("R2 R3 word sent MSB first", rx[31:0], 32'hA5C3_1E97);
        check("R4 R5 cmd full frame", cmd_a, 32'h1234_5678);
        check("R7 sdo idle after frame", sdo_a, 0);
    endtask

    task automatic t_short();
        logic [127:0] rx;
        run_frame(20, 128'h9_ABCD, 32'h8765_4321, 1'b0, rx);
        check("R5 short frame cmd", cmd_a, {32'h8765_4321 & 32'hFFF, 20'h0} >> 0 | 32'h0 | {12'h321, 20'h9_ABCD});
        check("R3 short frame bits", rx[19:0], 20'h87654);
    endtask

    task automatic t_long();
        logic [127:0] rx;
        run_frame(40, 128'h5A_DEAD_BEEF, 32'hC0FF_EE11, 1'b0, rx);
        check("R5 long frame cmd", cmd_a, 32'hDEAD_BEEF);
        check("R4 long frame word", rx[39:8], 32'hC0FF_EE11);
        check("R4 pass-through bits", rx[7:0], 8'h5A);
    endtask

    task automatic t_idle_clock();
        logic [127:0] rx;
        sdi_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk_in = 1'b1; wait_n(HALF);
            check("R10 R7 sdo with strobe high", sdo_a, 0);
            sclk_in = 1'b0; wait_n(HALF);
        end
        run_frame(0, '0, 32'h0F1E_2D3C, 1'b0, rx);
        check("R10 empty frame cmd", cmd_a, 32'h0F1E_2D3C);
    endtask

    task automatic t_coincide();
        logic [127:0] rx;
        run_frame(32, 128'h7654_3211, 32'h1111_2222, 1'b1, rx);
        check("R9 coincident capture in cmd", cmd_a, 32'h7654_3211);
        check("R7 sdo after coincident end", sdo_a, 0);
    endtask

    task automatic t_chain();
        logic [127:0] rx;
        use_chain = 1'b1;
        run_frame(64, {64'h0, 64'hAAAA_5555_0123_4567}, 32'h3C3C_F00D, 1'b0, rx);
        check("R8 last device word first", rx[63:32], 32'h3C3C_F00D);
        check("R8 first device word second", rx[31:0], 32'h3C3C_F00D);
        check("R8 first device cmd", cmd_a, 32'h0123_4567);
        check("R8 second device cmd", cmd_b, 32'hAAAA_5555);
        use_chain = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_short();
        t_long();
        t_idle_clock();
        t_coincide();
        t_chain();
        wait_n(4);
        check("R6 one pulse per frame", pulses, frames);
        check("R6 pulse width one cycle", bad_pulses, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule